// File: doc/BRIEF.md
# Charge Fail-Safe Timer Supervisor

This block guards a battery charger against charging for too long and against charging after a fault has been seen. It counts whole minutes of active charging and compares the count with a limit chosen by a 3-bit select code. Each step of the code doubles the limit, starting at five minutes. The top code turns expiry off altogether. Four single-bit comparator inputs report over-voltage, end-of-discharge voltage, battery over-temperature and battery under-temperature. Each one, and the timeout, is caught in a sticky flag. The OR of all five flags is a summary fail flag, and that flag pulls the charge-enable output low.

Software reaches the block through a write strobe that is only accepted inside a select-framed transaction. A write carries the timeout code and a clear bit. Once set, the clear bit holds the minute count, the prescaler and every fault flag at zero until the select line is released. The bit then drops by itself, so one clear covers exactly one transaction. A parameterised prescaler turns the system clock into the minute tick, which lets a bench run with a very short minute.

Top module: `chg_failsafe_sup`

## Requirements
- R1: After reset all five fault flags and the fail flag are 0, the timeout code is 000 (five minutes), and chg_en_o equals chg_req_i.
- R2: For code c in 0..6 (cfg_tsel_i as an unsigned number) the limit is 5·2^c minutes (5, 10, 20, 40, 80, 160, 320). flt_to_o sets once the elapsed minute count reaches the limit, and stays set.
- R3: Code 111 never sets flt_to_o, however long charging lasts.
- R4: Writing a new code does not reset the elapsed count. If the count is already at or beyond the new limit, flt_to_o sets within a few cycles.
- R5: Each fault flag sets on a single asserted clock sample of its raw input and stays set after the input returns to 0.
- R6: fail_o is 1 exactly when any of the five flags is 1, and chg_en_o is 0 whenever fail_o is 1.
- R7: A write with cfg_clr_i=1 zeroes the minute count and all flags. Until the transaction ends, fault inputs are ignored and the count stays at zero.
- R8: The clear bit drops on the rising edge of cs_n_i. After that, faults latch and time counts again.
- R9: Minutes accumulate only while chg_req_i is 1 and fail_o is 0. While charging is not requested, the count and flt_to_o stay unchanged.
- R10: A write strobe while cs_n_i is 1 is ignored: it neither clears flags nor changes the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n_i | input | 1 | Transaction select, active low |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_tsel_i | input | 3 | Timeout code carried by a write |
| cfg_clr_i | input | 1 | Clear bit carried by a write |
| chg_req_i | input | 1 | Charger requests charging |
| raw_ov_i | input | 1 | Over-voltage comparator |
| raw_edv_i | input | 1 | End-of-discharge comparator |
| raw_ht_i | input | 1 | High-temperature comparator |
| raw_lt_i | input | 1 | Low-temperature comparator |
| flt_ov_o | output | 1 | Latched over-voltage |
| flt_edv_o | output | 1 | Latched end-of-discharge |
| flt_ht_o | output | 1 | Latched high temperature |
| flt_lt_o | output | 1 | Latched low temperature |
| flt_to_o | output | 1 | Latched charge timeout |
| fail_o | output | 1 | OR of all latched flags |
| chg_en_o | output | 1 | Charge enable to the power stage |

## Verification
The hardest case to reach is a count that already lies beyond a limit that is only written later. Software cannot see or set the count, so the bench must first let charging run under a long limit. It then writes a shorter code inside a transaction that carries no clear, and checks that expiry follows almost at once. Pausing charging, and clearing in the middle of a held transaction, are reached the same way: directed sequences with cycle windows sized from the short prescaler ratio. Random fault masks then cover the flag combinations.

// File: rtl/fss_pkg.sv
package fss_pkg;
    localparam int unsigned TSEL_W = 3;
    localparam int unsigned FLT_N  = 4;
    localparam int unsigned MIN_W  = 9;
    localparam int unsigned BASE_MINUTES = 5;

    localparam logic [TSEL_W-1:0] TSEL_NEVER = '1;
    localparam logic [TSEL_W-1:0] TSEL_RESET = '0;

    // Bit order of the comparator fault vector
    typedef enum int unsigned {
        FI_OV  = 0,
        FI_EDV = 1,
        FI_HT  = 2,
        FI_LT  = 3
    } flt_idx_e;

    // Limit doubles per code step
    function automatic logic [MIN_W-1:0] limit_of(input logic [TSEL_W-1:0] code);
        return MIN_W'(BASE_MINUTES) << code;
    endfunction
endpackage

// File: rtl/fss_tick_gen.sv
module fss_tick_gen #(
    parameter int unsigned DIV = 60_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic clr_i,
    output logic tick_o
);
    localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          tick;
    } tg_state_t;

    tg_state_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.tick = 1'b0;
        if (clr_i) begin
            s_d.cnt = '0;
        end else if (en_i) begin
            if (s_q.cnt == LAST) begin
                s_d.cnt  = '0;
                s_d.tick = 1'b1;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign tick_o = s_q.tick;
endmodule

// File: rtl/fss_minute_timer.sv
module fss_minute_timer
    import fss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_i,
    input  logic              clr_i,
    input  logic [TSEL_W-1:0] sel_i,
    output logic [MIN_W-1:0]  cnt_o,
    output logic              to_o
);
    typedef struct packed {
        logic [MIN_W-1:0] cnt;
        logic             to;
    } mt_state_t;

    mt_state_t s_d, s_q;
    logic      limit_hit;

    always_comb begin
        limit_hit = (sel_i != TSEL_NEVER) && (s_q.cnt >= limit_of(sel_i));
        s_d = s_q;
        if (clr_i) begin
            s_d = '0;
        end else begin
            if (tick_i && !s_q.to && (s_q.cnt != '1))
                s_d.cnt = s_q.cnt + 1'b1;
            if (limit_hit)
                s_d.to = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;
    assign to_o  = s_q.to;
endmodule

// File: rtl/fss_fault_bank.sv
module fss_fault_bank #(
    parameter int unsigned N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic [N-1:0] raw_i,
    output logic [N-1:0] flag_o
);
    typedef struct packed {
        logic [N-1:0] flag;
    } fb_state_t;

    fb_state_t    s_d, s_q;
    logic [N-1:0] set_mask;

    // One sticky set term per comparator
    for (genvar g = 0; g < N; g++) begin : g_set
        assign set_mask[g] = raw_i[g] & ~s_q.flag[g];
    end

    always_comb begin
        s_d = s_q;
        if (clr_i) s_d.flag = '0;
        else       s_d.flag = s_q.flag | set_mask;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign flag_o = s_q.flag;
endmodule

// File: rtl/fss_cfg_port.sv
module fss_cfg_port
    import fss_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              wr_i,
    input  logic [TSEL_W-1:0] tsel_i,
    input  logic              clr_i,
    output logic [TSEL_W-1:0] tsel_o,
    output logic              clr_hold_o
);
    typedef struct packed {
        logic [TSEL_W-1:0] tsel;
        logic              clr;
        logic              cs_n_prev;
    } cp_state_t;

    localparam cp_state_t RESET_VAL = '{tsel: TSEL_RESET, clr: 1'b0, cs_n_prev: 1'b1};

    cp_state_t s_d, s_q;
    logic      accept;
    logic      release_edge;

    always_comb begin
        accept       = wr_i && !cs_n_i;
        release_edge = cs_n_i && !s_q.cs_n_prev;
        s_d           = s_q;
        s_d.cs_n_prev = cs_n_i;
        if (release_edge) s_d.clr = 1'b0;
        if (accept) begin
            s_d.tsel = tsel_i;
            if (clr_i) s_d.clr = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= RESET_VAL;
        else        s_q <= s_d;
    end

    assign tsel_o     = s_q.tsel;
    assign clr_hold_o = s_q.clr;
endmodule

// File: rtl/chg_failsafe_sup.sv
module chg_failsafe_sup
    import fss_pkg::*;
#(
    parameter int unsigned TICK_DIV = 60_000_000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_i,
    input  logic              cfg_wr_i,
    input  logic [TSEL_W-1:0] cfg_tsel_i,
    input  logic              cfg_clr_i,
    input  logic              chg_req_i,
    input  logic              raw_ov_i,
    input  logic              raw_edv_i,
    input  logic              raw_ht_i,
    input  logic              raw_lt_i,
    output logic              flt_ov_o,
    output logic              flt_edv_o,
    output logic              flt_ht_o,
    output logic              flt_lt_o,
    output logic              flt_to_o,
    output logic              fail_o,
    output logic              chg_en_o
);
    logic [TSEL_W-1:0] tsel_q;
    logic              clr_hold;
    logic              tick;
    logic              tick_en;
    logic [MIN_W-1:0]  min_cnt;
    logic              to_flag;
    logic [FLT_N-1:0]  raw_vec;
    logic [FLT_N-1:0]  flt_vec;

    assign raw_vec[FI_OV]  = raw_ov_i;
    assign raw_vec[FI_EDV] = raw_edv_i;
    assign raw_vec[FI_HT]  = raw_ht_i;
    assign raw_vec[FI_LT]  = raw_lt_i;

    fss_cfg_port u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n_i     (cs_n_i),
        .wr_i       (cfg_wr_i),
        .tsel_i     (cfg_tsel_i),
        .clr_i      (cfg_clr_i),
        .tsel_o     (tsel_q),
        .clr_hold_o (clr_hold)
    );

    assign tick_en = chg_req_i && !fail_o && !clr_hold;

    fss_tick_gen #(.DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .en_i   (tick_en),
        .clr_i  (clr_hold),
        .tick_o (tick)
    );

    fss_minute_timer u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .clr_i  (clr_hold),
        .sel_i  (tsel_q),
        .cnt_o  (min_cnt),
        .to_o   (to_flag)
    );

    fss_fault_bank #(.N(FLT_N)) u_faults (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (clr_hold),
        .raw_i  (raw_vec),
        .flag_o (flt_vec)
    );

    assign flt_ov_o  = flt_vec[FI_OV];
    assign flt_edv_o = flt_vec[FI_EDV];
    assign flt_ht_o  = flt_vec[FI_HT];
    assign flt_lt_o  = flt_vec[FI_LT];
    assign flt_to_o  = to_flag;
    assign fail_o    = (|flt_vec) | to_flag;
    assign chg_en_o  = chg_req_i & ~fail_o;
endmodule

// File: rtl/fss_checker.sv
module fss_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n_i,
    input logic       chg_req_i,
    input logic       fail_o,
    input logic       chg_en_o,
    input logic       flt_to_o,
    input logic [4:0] flags,
    input logic       clr_hold,
    input logic [2:0] tsel_q,
    input logic [8:0] min_cnt
);
    // R5
    sticky_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_hold) |=> ((flags & $past(flags)) == $past(flags)));

    // R6
    gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> !chg_en_o);

    // R3
    never_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tsel_q == 3'b111 && !flt_to_o) |=> !flt_to_o);

    // R7
    clear_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_hold |=> (!fail_o && min_cnt == '0));

    // R8
    clr_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_i) |=> !clr_hold);

    // R9
    pause_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!chg_req_i && !$past(chg_req_i) && !clr_hold) |=> $stable(min_cnt));
endmodule

bind chg_failsafe_sup fss_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n_i    (cs_n_i),
    .chg_req_i (chg_req_i),
    .fail_o    (fail_o),
    .chg_en_o  (chg_en_o),
    .flt_to_o  (flt_to_o),
    .flags     ({flt_to_o, flt_lt_o, flt_ht_o, flt_edv_o, flt_ov_o}),
    .clr_hold  (clr_hold),
    .tsel_q    (tsel_q),
    .min_cnt   (min_cnt)
);

// File: tb/chg_failsafe_sup_tb.sv
module chg_failsafe_sup_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DIV = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, wr = 1'b0, clr = 1'b0, chg_req = 1'b0;
    logic [2:0] tsel = 3'b000;
    logic ov = 0, edv = 0, ht = 0, lt = 0;
    logic f_ov, f_edv, f_ht, f_lt, f_to, fail, chg_en;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    chg_failsafe_sup #(.TICK_DIV(DIV)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .cfg_wr_i(wr),
        .cfg_tsel_i(tsel), .cfg_clr_i(clr), .chg_req_i(chg_req),
        .raw_ov_i(ov), .raw_edv_i(edv), .raw_ht_i(ht), .raw_lt_i(lt),
        .flt_ov_o(f_ov), .flt_edv_o(f_edv), .flt_ht_o(f_ht), .flt_lt_o(f_lt),
        .flt_to_o(f_to), .fail_o(fail), .chg_en_o(chg_en)
    );

    function automatic int limit_min(input int code);
        return 5 << code;
    endfunction

    function automatic logic [3:0] flag_vec();
        return {f_lt, f_ht, f_edv, f_ov};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic write_cfg(input logic [2:0] code, input logic c, input bit finish);
        @(negedge clk);
        cs_n = 1'b0; wr = 1'b1; tsel = code; clr = c;
        @(negedge clk);
        wr = 1'b0; clr = 1'b0;
        if (finish) begin
            cs_n = 1'b1;
            cycles(2);
        end
    endtask

    task automatic pulse(input logic [3:0] m);
        @(negedge clk);
        {lt, ht, edv, ov} = m;
        @(negedge clk);
        {lt, ht, edv, ov} = 4'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        cycles(3);
        rst_n = 1'b1;
        cycles(1);
        // R1 reset state
        check({fail, f_to, flag_vec()} == 6'b0, "R1 flags", {fail, f_to, flag_vec()}, 0);
        check(chg_en == 1'b0, "R1 chg_en idle", chg_en, 0);
        chg_req = 1'b1;
        cycles(1);
        check(chg_en == 1'b1, "R1 chg_en follows req", chg_en, 1);
        // R1 default five-minute limit
        cycles(limit_min(0)*DIV - 3);
        check(f_to == 1'b0, "R1 default before limit", f_to, 0);
        cycles(6);
        check(f_to == 1'b1, "R1 default expiry", f_to, 1);
        check(fail == 1'b1 && chg_en == 1'b0, "R6 timeout gates charge", chg_en, 0);

        // R2 every finite code
        for (int c = 0; c < 7; c++) begin
            write_cfg(3'(c), 1'b1, 1'b1);
            check(f_to == 1'b0, "R7 clear drops timeout", f_to, 0);
            cycles(limit_min(c)*DIV - 4);
            check(f_to == 1'b0, "R2 before limit", f_to, 0);
            cycles(7);
            check(f_to == 1'b1, "R2 at limit", f_to, 1);
        end

        // R3 never-expire code
        write_cfg(3'b111, 1'b1, 1'b1);
        cycles(700*DIV);
        check(f_to == 1'b0 && chg_en == 1'b1, "R3 no expiry", f_to, 0);

        // R4 shrink limit below elapsed count
        write_cfg(3'b101, 1'b1, 1'b1);
        cycles(30*DIV);
        check(f_to == 1'b0, "R4 long limit running", f_to, 0);
        write_cfg(3'b010, 1'b0, 1'b1);
        check(f_to == 1'b1, "R4 expiry after shrink", f_to, 1);

        // R9 pause while not requested
        write_cfg(3'b000, 1'b1, 1'b1);
        cycles(3*DIV);
        chg_req = 1'b0;
        cycles(100);
        check(f_to == 1'b0, "R9 paused no expiry", f_to, 0);
        chg_req = 1'b1;
        cycles(3*DIV + 6);
        check(f_to == 1'b1, "R9 resumes count", f_to, 1);

        // R5 single-sample latch
        write_cfg(3'b111, 1'b1, 1'b1);
        pulse(4'b0001);
        cycles(3);
        check(flag_vec() == 4'b0001, "R5 ov sticky", flag_vec(), 1);
        check(fail == 1'b1 && chg_en == 1'b0, "R6 fault gates charge", chg_en, 0);

        // R7 clear held through transaction
        write_cfg(3'b111, 1'b1, 1'b0);
        cycles(1);
        check(flag_vec() == 4'b0, "R7 clear wipes", flag_vec(), 0);
        pulse(4'b0100);
        cycles(1);
        check(f_ht == 1'b0, "R7 fault ignored in clear", f_ht, 0);
        // R8 release on select rise
        cs_n = 1'b1;
        cycles(2);
        pulse(4'b0100);
        cycles(1);
        check(f_ht == 1'b1, "R8 latches after release", f_ht, 1);

        // R10 write outside transaction ignored
        @(negedge clk);
        wr = 1'b1; clr = 1'b1; tsel = 3'b000;
        @(negedge clk);
        wr = 1'b0; clr = 1'b0;
        cycles(2);
        check(f_ht == 1'b1, "R10 stray write no clear", f_ht, 1);
        // code must still be 111: run past five minutes after a plain clear inside a transaction
        @(negedge clk);
        cs_n = 1'b0; wr = 1'b1; clr = 1'b1; tsel = 3'b111;
        @(negedge clk);
        wr = 1'b0; clr = 1'b0; cs_n = 1'b1;
        cycles(2);
        @(negedge clk);
        wr = 1'b1; tsel = 3'b000;
        @(negedge clk);
        wr = 1'b0;
        cycles(10*DIV);
        check(f_to == 1'b0, "R10 stray code ignored", f_to, 0);

        // R5 R6 random fault masks
        for (int i = 0; i < 24; i++) begin
            logic [3:0] m;
            m = 4'($urandom % 16);
            write_cfg(3'b111, 1'b1, 1'b1);
            pulse(m);
            cycles(2 + int'($urandom % 4));
            check(flag_vec() == m, "R5 random mask", flag_vec(), m);
            check(fail == (|m), "R6 random fail", fail, |m);
            check(chg_en == !(|m), "R6 random enable", chg_en, !(|m));
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule